// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block turns one 16-bit instruction word into the control fields that a 32-bit execution pipeline needs. The two top bits of the word pick one of three encodings: a register-register format with an 8-bit operation code, an immediate format with a 2-bit operation code and an 8-bit unsigned constant, and a conditional-branch format. The decoder reports which encoding it found and pulls out the register indices, the immediate or the branch condition. It drives one select line per operation class, gives the total instruction length in bytes, and raises a flag for any encoding it does not recognise.

The block also produces the ALU function code and a mask for the B operand. The mask cuts the shift count down to its low five bits for every shift. For memory operations it gives the access size, whether a narrow load is zero-extended, and the addressing mode. The block is purely combinational and has no clock. The pipeline drives `valid_i` along with the word. Fetching the 32-bit extension word, executing the operation and accessing memory are left to the surrounding pipeline.

Top module: `tri_format_decoder`

## Requirements
- R1: `fmt_o` is 0 when opcode bit 15 is 0, 1 when bits 15:14 are 10, and 2 when bits 15:14 are 11.
- R2: In format 0, `reg_a_o` = bits 7:4 and `reg_b_o` = bits 3:0. In format 1, `reg_a_o` = bits 11:8 and `imm_o` = bits 7:0 zero-extended. In format 2, `cond_o` = bits 13:10. Every field that the current format does not define reads 0.
- R3: In format 1, bits 13:12 pick the operation. Values 0 and 1 select the ALU-immediate class with function add (1) or subtract (2). Value 2 selects special-register read and value 3 selects special-register write, both with function add (1).
- R4: In format 0, the following codes select the ALU-register class with these `alu_fn_o` values: 02→0 (pass B), 05→1 (add), 29→2 (sub), 26→3 (and), 2B→4 (or), 2E→5 (xor), 2C→6 (not), 2A→7 (negate), 28→8 (shift left), 27→9 (logical shift right), 2D→10 (arithmetic shift right), 2F→11 (mul), 31→12 (div), 32→13 (unsigned div), 33→14 (rem), 34→15 (unsigned rem). Code 0E compares and gives function 2. Every other operation gives function 1.
- R5: `alu_b_mask_o` is 0x0000001F when `alu_fn_o` is 8, 9 or 10, and all ones otherwise.
- R6: `len_o` is 6 for the format-0 codes 01, 03, 08, 09, 0C, 0D, 1A, 1B, 1D, 1F, 20, 22, 24, 30 and 36 to 39. It is 2 for every other encoding, including illegal ones.
- R7: Memory size is encoded 0 = byte, 1 = half, 2 = word. Addressing mode is encoded 0 = none, 1 = register indirect, 2 = absolute, 3 = base plus offset. The loads are 0A, 08, 0C (word), 1C, 1D, 36 (byte) and 21, 22, 38 (half), each group listed in modes 1, 2, 3. The stores are 0B, 09, 0D, 1E, 1F, 37, 23, 24 and 39, laid out the same way. Push 06 and pop 07 are word-sized with mode 1. `mem_zext_o` is 1 only for byte and half loads. Every other operation reports word size and mode 0.
- R8: These format-0 codes select classes: 01, 1B and 20 load-immediate; 03 and 19 call; 04 return; 1A and 25 jump; 06 push; 07 pop; 0E compare; 30 software interrupt; 35 breakpoint.
- R9: In format 2, condition values 0 to 9 select the branch class. Values 10 to 15 are illegal.
- R10: Every format-0 code not named in R4, R7 or R8 is illegal. This includes 00, 0F to 18 and 3A to 7F. An illegal word selects no class and has length 2.
- R11: While `valid_i` is 0, all `op_sel_o` bits and `illegal_o` are 0. The field outputs still follow the opcode.
- R12: `op_sel_o` bits, from bit 0 up: ALU-register, ALU-immediate, load-immediate, load, store, push, pop, call, return, jump, branch, compare, special read, special write, software interrupt, breakpoint. While valid, exactly one of these bits or `illegal_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | Instruction word is present |
| opcode_i | input | 16 | Instruction word |
| fmt_o | output | 2 | Encoding format 0, 1 or 2 |
| op_sel_o | output | 16 | One-hot operation class |
| len_o | output | 3 | Instruction length in bytes |
| illegal_o | output | 1 | Unrecognised encoding while valid |
| reg_a_o | output | 4 | First register index |
| reg_b_o | output | 4 | Second register index |
| imm_o | output | DATA_W | Zero-extended 8-bit immediate |
| cond_o | output | 4 | Branch condition code |
| mem_size_o | output | 2 | Access size |
| mem_zext_o | output | 1 | Zero-extend a narrow load |
| addr_mode_o | output | 2 | Address computation mode |
| alu_fn_o | output | 4 | ALU function |
| alu_b_mask_o | output | DATA_W | Mask for the B operand |

## Verification
The embedded checks assume that `valid_i` and `opcode_i` are never X or Z. They also assume that both inputs stay stable long enough for the output cone to settle, because each check reads outputs of separate sub-decoders together. The stimulus changes both inputs only on the falling edge of the bench clock and samples on the rising edge. It always drives defined values: a full sweep of the 65536 words with valid high, and chosen words with valid low, including during reset.

// File: rtl/itd_pkg.sv
package itd_pkg;

  localparam int OPC_W     = 16;
  localparam int RIDX_W    = 4;
  localparam int F1_CODE_W = 8;
  localparam int F2_CODE_W = 2;
  localparam int COND_W    = 4;
  localparam int IMM8_W    = 8;
  localparam int NUM_COND  = 10;
  localparam int NUM_OPS   = 16;

  typedef enum logic [1:0] {
    FMT_REG = 2'd0,
    FMT_IMM = 2'd1,
    FMT_BR  = 2'd2
  } fmt_e;

  typedef enum logic [3:0] {
    OPS_ALU_RR  = 4'd0,
    OPS_ALU_IMM = 4'd1,
    OPS_LDI     = 4'd2,
    OPS_LOAD    = 4'd3,
    OPS_STORE   = 4'd4,
    OPS_PUSH    = 4'd5,
    OPS_POP     = 4'd6,
    OPS_CALL    = 4'd7,
    OPS_RET     = 4'd8,
    OPS_JUMP    = 4'd9,
    OPS_BRANCH  = 4'd10,
    OPS_CMP     = 4'd11,
    OPS_SRD     = 4'd12,
    OPS_SWR     = 4'd13,
    OPS_SWI     = 4'd14,
    OPS_BRK     = 4'd15
  } op_e;

  typedef enum logic [3:0] {
    FN_PASS = 4'd0,  FN_ADD  = 4'd1,  FN_SUB  = 4'd2,  FN_AND  = 4'd3,
    FN_OR   = 4'd4,  FN_XOR  = 4'd5,  FN_NOT  = 4'd6,  FN_NEG  = 4'd7,
    FN_SHL  = 4'd8,  FN_SHR  = 4'd9,  FN_SAR  = 4'd10, FN_MUL  = 4'd11,
    FN_DIV  = 4'd12, FN_UDIV = 4'd13, FN_MOD  = 4'd14, FN_UMOD = 4'd15
  } alu_fn_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } msize_e;

  typedef enum logic [1:0] {
    AM_NONE = 2'd0,
    AM_REG  = 2'd1,
    AM_ABS  = 2'd2,
    AM_OFS  = 2'd3
  } amode_e;

  typedef struct packed {
    logic    legal;
    op_e     op;
    alu_fn_e fn;
    logic    ext;
    msize_e  size;
    logic    zext;
    amode_e  am;
  } dec_t;

  function automatic dec_t dec_none();
    dec_t d;
    d.legal = 1'b0;
    d.op    = OPS_ALU_RR;
    d.fn    = FN_ADD;
    d.ext   = 1'b0;
    d.size  = SZ_WORD;
    d.zext  = 1'b0;
    d.am    = AM_NONE;
    return d;
  endfunction

  function automatic dec_t dec_ctl(input op_e op, input logic ext);
    dec_t d;
    d       = dec_none();
    d.legal = 1'b1;
    d.op    = op;
    d.ext   = ext;
    return d;
  endfunction

  function automatic dec_t dec_alu(input alu_fn_e fn);
    dec_t d;
    d    = dec_ctl(OPS_ALU_RR, 1'b0);
    d.fn = fn;
    return d;
  endfunction

  function automatic dec_t dec_mem(input op_e op, input msize_e size, input amode_e am);
    dec_t d;
    d      = dec_ctl(op, (am == AM_ABS) || (am == AM_OFS));
    d.size = size;
    d.am   = am;
    d.zext = (op == OPS_LOAD) && (size != SZ_WORD);
    return d;
  endfunction

endpackage

// File: rtl/itd_fields.sv
module itd_fields
  import itd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OPC_W-1:0]     opcode_i,
  output fmt_e                 fmt_o,
  output logic [F1_CODE_W-1:0] f1_code_o,
  output logic [F2_CODE_W-1:0] f2_code_o,
  output logic [COND_W-1:0]    cond_o,
  output logic [RIDX_W-1:0]    reg_a_o,
  output logic [RIDX_W-1:0]    reg_b_o,
  output logic [DATA_W-1:0]    imm_o
);

  localparam int TOP_BIT  = OPC_W - 1;
  localparam int SUB_BIT  = OPC_W - 2;
  localparam int F2_LO    = SUB_BIT - F2_CODE_W;
  localparam int F2_REGLO = F2_LO - RIDX_W;
  localparam int COND_LO  = SUB_BIT - COND_W;

  always_comb begin
    f1_code_o = opcode_i[OPC_W-1 -: F1_CODE_W];
    f2_code_o = opcode_i[F2_LO +: F2_CODE_W];
    fmt_o     = FMT_REG;
    cond_o    = '0;
    reg_a_o   = '0;
    reg_b_o   = '0;
    imm_o     = '0;
    if (!opcode_i[TOP_BIT]) begin
      fmt_o   = FMT_REG;
      reg_a_o = opcode_i[RIDX_W +: RIDX_W];
      reg_b_o = opcode_i[0 +: RIDX_W];
    end else if (!opcode_i[SUB_BIT]) begin
      fmt_o   = FMT_IMM;
      reg_a_o = opcode_i[F2_REGLO +: RIDX_W];
      imm_o   = DATA_W'(opcode_i[0 +: IMM8_W]);
    end else begin
      fmt_o   = FMT_BR;
      cond_o  = opcode_i[COND_LO +: COND_W];
    end
  end

endmodule

// File: rtl/itd_f1_table.sv
module itd_f1_table
  import itd_pkg::*;
(
  input  logic [F1_CODE_W-1:0] code_i,
  output dec_t                 dec_o
);

  always_comb begin
    dec_o = dec_none();
    case (code_i)
      8'h01, 8'h1B, 8'h20: dec_o = dec_ctl(OPS_LDI, 1'b1);
      8'h02: dec_o = dec_alu(FN_PASS);
      8'h03: dec_o = dec_ctl(OPS_CALL, 1'b1);
      8'h04: dec_o = dec_ctl(OPS_RET, 1'b0);
      8'h05: dec_o = dec_alu(FN_ADD);
      8'h06: dec_o = dec_mem(OPS_PUSH,  SZ_WORD, AM_REG);
      8'h07: dec_o = dec_mem(OPS_POP,   SZ_WORD, AM_REG);
      8'h08: dec_o = dec_mem(OPS_LOAD,  SZ_WORD, AM_ABS);
      8'h09: dec_o = dec_mem(OPS_STORE, SZ_WORD, AM_ABS);
      8'h0A: dec_o = dec_mem(OPS_LOAD,  SZ_WORD, AM_REG);
      8'h0B: dec_o = dec_mem(OPS_STORE, SZ_WORD, AM_REG);
      8'h0C: dec_o = dec_mem(OPS_LOAD,  SZ_WORD, AM_OFS);
      8'h0D: dec_o = dec_mem(OPS_STORE, SZ_WORD, AM_OFS);
      8'h0E: begin
        dec_o    = dec_ctl(OPS_CMP, 1'b0);
        dec_o.fn = FN_SUB;
      end
      8'h19: dec_o = dec_ctl(OPS_CALL, 1'b0);
      8'h1A: dec_o = dec_ctl(OPS_JUMP, 1'b1);
      8'h1C: dec_o = dec_mem(OPS_LOAD,  SZ_BYTE, AM_REG);
      8'h1D: dec_o = dec_mem(OPS_LOAD,  SZ_BYTE, AM_ABS);
      8'h1E: dec_o = dec_mem(OPS_STORE, SZ_BYTE, AM_REG);
      8'h1F: dec_o = dec_mem(OPS_STORE, SZ_BYTE, AM_ABS);
      8'h21: dec_o = dec_mem(OPS_LOAD,  SZ_HALF, AM_REG);
      8'h22: dec_o = dec_mem(OPS_LOAD,  SZ_HALF, AM_ABS);
      8'h23: dec_o = dec_mem(OPS_STORE, SZ_HALF, AM_REG);
      8'h24: dec_o = dec_mem(OPS_STORE, SZ_HALF, AM_ABS);
      8'h25: dec_o = dec_ctl(OPS_JUMP, 1'b0);
      8'h26: dec_o = dec_alu(FN_AND);
      8'h27: dec_o = dec_alu(FN_SHR);
      8'h28: dec_o = dec_alu(FN_SHL);
      8'h29: dec_o = dec_alu(FN_SUB);
      8'h2A: dec_o = dec_alu(FN_NEG);
      8'h2B: dec_o = dec_alu(FN_OR);
      8'h2C: dec_o = dec_alu(FN_NOT);
      8'h2D: dec_o = dec_alu(FN_SAR);
      8'h2E: dec_o = dec_alu(FN_XOR);
      8'h2F: dec_o = dec_alu(FN_MUL);
      8'h30: dec_o = dec_ctl(OPS_SWI, 1'b1);
      8'h31: dec_o = dec_alu(FN_DIV);
      8'h32: dec_o = dec_alu(FN_UDIV);
      8'h33: dec_o = dec_alu(FN_MOD);
      8'h34: dec_o = dec_alu(FN_UMOD);
      8'h35: dec_o = dec_ctl(OPS_BRK, 1'b0);
      8'h36: dec_o = dec_mem(OPS_LOAD,  SZ_BYTE, AM_OFS);
      8'h37: dec_o = dec_mem(OPS_STORE, SZ_BYTE, AM_OFS);
      8'h38: dec_o = dec_mem(OPS_LOAD,  SZ_HALF, AM_OFS);
      8'h39: dec_o = dec_mem(OPS_STORE, SZ_HALF, AM_OFS);
      default: dec_o = dec_none();
    endcase
  end

endmodule

// File: rtl/itd_f23_decode.sv
module itd_f23_decode
  import itd_pkg::*;
(
  input  fmt_e                 fmt_i,
  input  logic [F2_CODE_W-1:0] code_i,
  input  logic [COND_W-1:0]    cond_i,
  output dec_t                 dec_o
);

  localparam logic [COND_W-1:0] COND_LIMIT = COND_W'(NUM_COND);

  always_comb begin
    dec_o = dec_none();
    if (fmt_i == FMT_IMM) begin
      case (code_i)
        2'd0: dec_o = dec_ctl(OPS_ALU_IMM, 1'b0);
        2'd1: begin
          dec_o    = dec_ctl(OPS_ALU_IMM, 1'b0);
          dec_o.fn = FN_SUB;
        end
        2'd2: dec_o = dec_ctl(OPS_SRD, 1'b0);
        default: dec_o = dec_ctl(OPS_SWR, 1'b0);
      endcase
    end else if (fmt_i == FMT_BR) begin
      if (cond_i < COND_LIMIT) begin
        dec_o = dec_ctl(OPS_BRANCH, 1'b0);
      end
    end
  end

endmodule

// File: rtl/itd_alu_ctrl.sv
module itd_alu_ctrl
  import itd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_fn_e           fn_i,
  output logic [3:0]        fn_o,
  output logic [DATA_W-1:0] b_mask_o
);

  localparam int SHAMT_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] SHIFT_MASK = DATA_W'({SHAMT_W{1'b1}});

  logic is_shift;

  always_comb begin
    is_shift = (fn_i == FN_SHL) || (fn_i == FN_SHR) || (fn_i == FN_SAR);
    fn_o     = fn_i;
    b_mask_o = '1;
    if (is_shift) begin
      b_mask_o = SHIFT_MASK;
    end
  end

endmodule

// File: rtl/tri_format_decoder.sv
module tri_format_decoder
  import itd_pkg::*;
#(
  parameter int  DATA_W    = 32,
  localparam int SHORT_LEN = OPC_W / 8,
  localparam int LONG_LEN  = SHORT_LEN + DATA_W / 8,
  localparam int LEN_W     = $clog2(LONG_LEN + 1),
  localparam int SHAMT_W   = $clog2(DATA_W)
) (
  input  logic                 valid_i,
  input  logic [OPC_W-1:0]     opcode_i,
  output logic [1:0]           fmt_o,
  output logic [NUM_OPS-1:0]   op_sel_o,
  output logic [LEN_W-1:0]     len_o,
  output logic                 illegal_o,
  output logic [RIDX_W-1:0]    reg_a_o,
  output logic [RIDX_W-1:0]    reg_b_o,
  output logic [DATA_W-1:0]    imm_o,
  output logic [COND_W-1:0]    cond_o,
  output logic [1:0]           mem_size_o,
  output logic                 mem_zext_o,
  output logic [1:0]           addr_mode_o,
  output logic [3:0]           alu_fn_o,
  output logic [DATA_W-1:0]    alu_b_mask_o
);

  fmt_e                 fmt;
  logic [F1_CODE_W-1:0] f1_code;
  logic [F2_CODE_W-1:0] f2_code;
  dec_t                 f1_dec;
  dec_t                 f23_dec;
  dec_t                 dec;

  itd_fields #(.DATA_W(DATA_W)) u_fields (
    .opcode_i  (opcode_i),
    .fmt_o     (fmt),
    .f1_code_o (f1_code),
    .f2_code_o (f2_code),
    .cond_o    (cond_o),
    .reg_a_o   (reg_a_o),
    .reg_b_o   (reg_b_o),
    .imm_o     (imm_o)
  );

  itd_f1_table u_f1 (
    .code_i (f1_code),
    .dec_o  (f1_dec)
  );

  itd_f23_decode u_f23 (
    .fmt_i  (fmt),
    .code_i (f2_code),
    .cond_i (cond_o),
    .dec_o  (f23_dec)
  );

  always_comb begin
    dec         = (fmt == FMT_REG) ? f1_dec : f23_dec;
    fmt_o       = fmt;
    illegal_o   = valid_i && !dec.legal;
    len_o       = (dec.legal && dec.ext) ? LEN_W'(LONG_LEN) : LEN_W'(SHORT_LEN);
    mem_size_o  = dec.size;
    mem_zext_o  = dec.zext;
    addr_mode_o = dec.am;
  end

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_sel
    assign op_sel_o[k] = valid_i && dec.legal && (int'(dec.op) == k);
  end

  itd_alu_ctrl #(.DATA_W(DATA_W)) u_alu (
    .fn_i     (dec.fn),
    .fn_o     (alu_fn_o),
    .b_mask_o (alu_b_mask_o)
  );

  always_comb begin
    assert_sel_onehot_R12: assert ($onehot0(op_sel_o))
      else $error("op_sel_o carries more than one class");
    assert_class_or_flag_R12: assert (!valid_i || ((|op_sel_o) != illegal_o))
      else $error("valid word neither classified nor flagged");
    assert_idle_quiet_R11: assert (valid_i || (op_sel_o == '0 && !illegal_o))
      else $error("outputs active while valid_i low");
    assert_len_pair_R6: assert (len_o == LEN_W'(SHORT_LEN) || len_o == LEN_W'(LONG_LEN))
      else $error("length outside the two legal values");
    assert_illegal_short_R10: assert (!illegal_o || len_o == LEN_W'(SHORT_LEN))
      else $error("illegal word given the long length");
    assert_branch_fmt_R9: assert (!op_sel_o[OPS_BRANCH] || fmt_o == FMT_BR)
      else $error("branch class outside format 2");
    assert_shift_mask_R5: assert (!(alu_fn_o inside {FN_SHL, FN_SHR, FN_SAR}) ||
                                  $countones(alu_b_mask_o) == SHAMT_W)
      else $error("shift without count mask");
  end

endmodule

// File: tb/tb_tri_format_decoder.sv
module tb_tri_format_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              valid;
  logic [15:0]       opc;
  logic [1:0]        fmt;
  logic [15:0]       op_sel;
  logic [2:0]        len;
  logic              ill;
  logic [3:0]        ra, rb, cond;
  logic [DATA_W-1:0] imm;
  logic [1:0]        msz;
  logic              mzx;
  logic [1:0]        am;
  logic [3:0]        fn;
  logic [DATA_W-1:0] mask;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  typedef struct packed {
    logic [15:0] o;
    logic        v;
    logic [1:0]  fmt;
    logic [15:0] op;
    logic [2:0]  len;
    logic        ill;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [3:0]  cond;
    logic [31:0] imm;
    logic [1:0]  sz;
    logic        zx;
    logic [1:0]  am;
    logic [3:0]  fn;
    logic [31:0] mask;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_format_decoder #(.DATA_W(DATA_W)) dut (
    .valid_i      (valid),
    .opcode_i     (opc),
    .fmt_o        (fmt),
    .op_sel_o     (op_sel),
    .len_o        (len),
    .illegal_o    (ill),
    .reg_a_o      (ra),
    .reg_b_o      (rb),
    .imm_o        (imm),
    .cond_o       (cond),
    .mem_size_o   (msz),
    .mem_zext_o   (mzx),
    .addr_mode_o  (am),
    .alu_fn_o     (fn),
    .alu_b_mask_o (mask)
  );

  function automatic exp_t model(input logic [15:0] o, input logic v);
    exp_t e;
    logic [7:0] c;
    int k;
    logic lng;
    c = o[15:8];
    e = '0;
    e.o = o; e.v = v; e.sz = 2'd2; e.fn = 4'd1; e.mask = '1;
    k = -1; lng = 1'b0;
    if (!o[15]) begin
      e.fmt = 2'd0; e.ra = o[7:4]; e.rb = o[3:0];
      case (c)
        8'h02: begin k = 0; e.fn = 4'd0;  end
        8'h05: begin k = 0; e.fn = 4'd1;  end
        8'h29: begin k = 0; e.fn = 4'd2;  end
        8'h26: begin k = 0; e.fn = 4'd3;  end
        8'h2B: begin k = 0; e.fn = 4'd4;  end
        8'h2E: begin k = 0; e.fn = 4'd5;  end
        8'h2C: begin k = 0; e.fn = 4'd6;  end
        8'h2A: begin k = 0; e.fn = 4'd7;  end
        8'h28: begin k = 0; e.fn = 4'd8;  end
        8'h27: begin k = 0; e.fn = 4'd9;  end
        8'h2D: begin k = 0; e.fn = 4'd10; end
        8'h2F: begin k = 0; e.fn = 4'd11; end
        8'h31: begin k = 0; e.fn = 4'd12; end
        8'h32: begin k = 0; e.fn = 4'd13; end
        8'h33: begin k = 0; e.fn = 4'd14; end
        8'h34: begin k = 0; e.fn = 4'd15; end
        8'h0E: begin k = 11; e.fn = 4'd2; end
        8'h01, 8'h1B, 8'h20: k = 2;
        8'h03, 8'h19: k = 7;
        8'h04: k = 8;
        8'h1A, 8'h25: k = 9;
        8'h06: k = 5;
        8'h07: k = 6;
        8'h30: k = 14;
        8'h35: k = 15;
        default: k = -1;
      endcase
      if (c inside {8'h0A, 8'h08, 8'h0C, 8'h1C, 8'h1D, 8'h36, 8'h21, 8'h22, 8'h38}) k = 3;
      if (c inside {8'h0B, 8'h09, 8'h0D, 8'h1E, 8'h1F, 8'h37, 8'h23, 8'h24, 8'h39}) k = 4;
      if (c inside {8'h1C, 8'h1D, 8'h36, 8'h1E, 8'h1F, 8'h37}) e.sz = 2'd0;
      if (c inside {8'h21, 8'h22, 8'h38, 8'h23, 8'h24, 8'h39}) e.sz = 2'd1;
      if (c inside {8'h0A, 8'h0B, 8'h1C, 8'h1E, 8'h21, 8'h23, 8'h06, 8'h07}) e.am = 2'd1;
      if (c inside {8'h08, 8'h09, 8'h1D, 8'h1F, 8'h22, 8'h24}) e.am = 2'd2;
      if (c inside {8'h0C, 8'h0D, 8'h36, 8'h37, 8'h38, 8'h39}) e.am = 2'd3;
      e.zx = (k == 3) && (e.sz != 2'd2);
      lng = c inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D, 8'h1A, 8'h1B, 8'h1D,
                      8'h1F, 8'h20, 8'h22, 8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39};
    end else if (!o[14]) begin
      e.fmt = 2'd1; e.ra = o[11:8]; e.imm = {24'h0, o[7:0]};
      case (o[13:12])
        2'd0: k = 1;
        2'd1: begin k = 1; e.fn = 4'd2; end
        2'd2: k = 12;
        default: k = 13;
      endcase
    end else begin
      e.fmt = 2'd2; e.cond = o[13:10];
      k = (o[13:10] <= 4'd9) ? 10 : -1;
    end
    if (e.fn inside {4'd8, 4'd9, 4'd10}) e.mask = 32'h0000_001F;
    e.len = (k >= 0 && lng) ? 3'd6 : 3'd2;
    e.ill = v && (k < 0);
    e.op  = (v && k >= 0) ? (16'(1) << k) : 16'h0;
    return e;
  endfunction

  task automatic chk(input string req, input string name, input logic [15:0] o,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s opcode=%h actual=%h expected=%h", req, name, o, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] o, input logic v);
    @(negedge clk);
    opc   = o;
    valid = v;
    q.push_back(model(o, v));
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      string rop;
      e = q.pop_front();
      if (!e.v)               rop = "R11";
      else if (e.fmt == 2'd2) rop = "R9";
      else if (e.fmt == 2'd1) rop = "R3";
      else                    rop = "R8";
      chk("R1", "fmt", e.o, 32'(fmt), 32'(e.fmt));
      chk("R2", "reg_a", e.o, 32'(ra), 32'(e.ra));
      chk("R2", "reg_b", e.o, 32'(rb), 32'(e.rb));
      chk("R2", "imm", e.o, imm, e.imm);
      chk("R2", "cond", e.o, 32'(cond), 32'(e.cond));
      chk(rop, "op_sel", e.o, 32'(op_sel), 32'(e.op));
      chk(e.v ? "R10" : "R11", "illegal", e.o, 32'(ill), 32'(e.ill));
      chk("R6", "len", e.o, 32'(len), 32'(e.len));
      chk("R7", "mem_size", e.o, 32'(msz), 32'(e.sz));
      chk("R7", "mem_zext", e.o, 32'(mzx), 32'(e.zx));
      chk("R7", "addr_mode", e.o, 32'(am), 32'(e.am));
      chk("R4", "alu_fn", e.o, 32'(fn), 32'(e.fn));
      chk("R5", "b_mask", e.o, mask, e.mask);
      if (e.v) begin
        chk("R12", "class_count", e.o, 32'($countones(op_sel)) + 32'(ill), 32'd1);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    valid = 1'b0;
    opc   = '0;
    // R11: reset phase, valid held low with decodable words present
    send(16'h0000, 1'b0);
    send(16'h2812, 1'b0);
    send(16'hC123, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1..R10, R12: every instruction word with valid high
    for (int w = 0; w < 65536; w++) begin
      send(16'(w), 1'b1);
    end
    // R11: valid low against legal, illegal, long and branch words
    send(16'h0145, 1'b0);
    send(16'h0F00, 1'b0);
    send(16'h9A7F, 1'b0);
    send(16'hFFFF, 1'b0);
    send(16'h2D3C, 1'b0);
    // R5: shift words after idle
    send(16'h2D3C, 1'b1);
    send(16'h2700, 1'b1);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule